// File: doc/BRIEF.md
# Fault Event Capture Buffer

This block keeps a rolling record of incoming multi-channel sample frames in a circular memory, tagging each stored frame with the value of a free-running timestamp counter. Once armed by the host, it writes every valid frame over the oldest entry. When a fault trigger arrives, the frames already written become the pre-event history, up to the programmed pre-trigger length. The block then stores a programmed number of further frames and stops writing.

When the post-trigger tail is complete, the block freezes and raises a done flag. The host then reads the captured window out in time order, starting at the oldest history frame and wrapping around the memory. While a capture is running, the busy flag acts as an interlock. Host reads, re-arm requests and further triggers are all refused until the capture is finished. If the trigger arrives before a full history has built up, the capture still proceeds with a shorter history, and a flag reports this to the host.

Top module: `fault_capture_buf`

## Requirements
- R1: After reset the block is idle: busy, done, shortPre and rdValid are all low.
- R2: A pulse on armIn while busy is low moves the block to recording. busy is high one cycle later, and done and shortPre are cleared. armIn while busy is high has no effect.
- R3: While armed and not triggered, every frame with frameValid high is written to the next circular address. A frame presented in the same cycle as an accepted trigger is discarded.
- R4: An accepted trigger keeps as history the last min(N, preLen) frames written since arming, where N is the number written. shortPre goes high when N < preLen. preLen + postLen must not exceed DEPTH.
- R5: After a trigger, exactly postLen further valid frames are stored. One cycle later busy falls and done rises. Frames arriving after that are not stored.
- R6: trigIn is ignored unless the block is armed and not yet triggered. This covers the idle state, the post-trigger phase and the done state.
- R7: In the done state, each rdEn pulse returns one entry on rdData with rdValid high in the next cycle. The entries come oldest history frame first, then the rest of the history, then the post-trigger frames, wrapping modulo DEPTH.
- R8: rdData is {timestamp, frame}. The frame occupies the low NCH*CH_W bits. The timestamp occupies the top TS_W bits and is the value of a counter that resets to 0 and increments every clock, taken in the cycle the frame was written.
- R9: rdEn while done is low produces no rdValid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| frameValid | input | 1 | Strobe marking a valid sample frame |
| frameData | input | NCH*CH_W | Sample frame, all channels packed |
| trigIn | input | 1 | Fault event trigger |
| preLen | input | $clog2(DEPTH)+1 | Number of history frames to keep |
| postLen | input | $clog2(DEPTH)+1 | Number of frames to store after the trigger |
| armIn | input | 1 | Host request to start a new capture; also clears done |
| rdEn | input | 1 | Host read request for the next captured entry |
| rdData | output | TS_W+NCH*CH_W | Captured entry: timestamp above frame |
| rdValid | output | 1 | rdData holds a fresh entry |
| busy | output | 1 | Capture in progress (interlock) |
| done | output | 1 | Capture complete, window readable |
| shortPre | output | 1 | Last capture had fewer history frames than preLen |

## Verification
The bench builds the block with DEPTH = 8, two 16-bit channels and a 16-bit timestamp. With a memory this small, a few dozen frames wrap the write pointer several times per capture. The same depth makes the edge cases cheap to reach: a history that fills the entire memory, an empty history, an empty tail and a premature trigger. Gapped frame streams give timestamps with uneven spacing, which tests that each timestamp comes from the cycle its frame was written.

// File: rtl/fcap_pkg.sv
package fcap_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_POST  = 2'd2,
    ST_DONE  = 2'd3
  } capState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic wr;       // store the presented frame
    logic capTrig;  // trigger accepted: fix the read start
    logic rd;       // pop one entry to the host
  } capStrobe_t;

endpackage

// File: rtl/fcap_ctrl.sv
module fcap_ctrl
  import fcap_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             frameValid,
  input  logic             trigIn,
  input  logic             armIn,
  input  logic             rdEn,
  input  logic [CNT_W-1:0] preLen,
  input  logic [CNT_W-1:0] postLen,
  output capStrobe_t       strb,
  output logic [CNT_W-1:0] keptPre,
  output logic             busy,
  output logic             done,
  output logic             shortPre
);

  capState_t state, nxtState;
  logic [CNT_W-1:0] fillCnt;
  logic [CNT_W-1:0] postCnt;
  logic armAccept;

  assign armAccept = armIn && (state == ST_IDLE || state == ST_DONE);

  always_comb begin
    strb     = '0;
    nxtState = state;
    unique case (state)
      ST_IDLE: begin
        if (armIn) nxtState = ST_ARMED;
      end
      ST_ARMED: begin
        if (trigIn) begin
          strb.capTrig = 1'b1;
          nxtState     = ST_POST;
        end else if (frameValid) begin
          strb.wr = 1'b1;
        end
      end
      ST_POST: begin
        if (postCnt == postLen) nxtState = ST_DONE;
        else if (frameValid)    strb.wr = 1'b1;
      end
      ST_DONE: begin
        strb.rd = rdEn;
        if (armIn) nxtState = ST_ARMED;
      end
      default: nxtState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      fillCnt  <= '0;
      postCnt  <= '0;
      shortPre <= 1'b0;
    end else begin
      state <= nxtState;
      if (armAccept) begin
        fillCnt  <= '0;
        shortPre <= 1'b0;
      end else if (state == ST_ARMED && strb.wr && fillCnt < preLen) begin
        fillCnt <= fillCnt + 1'b1;
      end
      if (strb.capTrig) begin
        shortPre <= (fillCnt < preLen);
        postCnt  <= '0;
      end else if (state == ST_POST && strb.wr) begin
        postCnt <= postCnt + 1'b1;
      end
    end
  end

  // fillCnt saturates at preLen, so it is already min(written, preLen)
  assign keptPre = fillCnt;
  assign busy    = (state == ST_ARMED) || (state == ST_POST);
  assign done    = (state == ST_DONE);

endmodule

// File: rtl/fcap_path.sv
module fcap_path
  import fcap_pkg::*;
#(
  parameter int FRAME_W = 32,
  parameter int TS_W    = 16,
  parameter int DEPTH   = 16,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int CNT_W  = ADDR_W + 1,
  localparam int ENT_W  = TS_W + FRAME_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  capStrobe_t         strb,
  input  logic [FRAME_W-1:0] frameData,
  input  logic [CNT_W-1:0]   keptPre,
  output logic [ENT_W-1:0]   rdData,
  output logic               rdValid
);

  logic [ENT_W-1:0]  mem [DEPTH];
  logic [ADDR_W-1:0] wrPtr;
  logic [ADDR_W-1:0] rdPtr;
  logic [TS_W-1:0]   tsCnt;

  always_ff @(posedge clk) begin
    if (strb.wr) mem[wrPtr] <= {tsCnt, frameData};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr   <= '0;
      rdPtr   <= '0;
      tsCnt   <= '0;
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      tsCnt   <= tsCnt + 1'b1;
      rdValid <= strb.rd;
      if (strb.wr) wrPtr <= wrPtr + 1'b1;
      // power-of-two depth: truncated subtraction wraps
      if (strb.capTrig) rdPtr <= wrPtr - keptPre[ADDR_W-1:0];
      else if (strb.rd) begin
        rdData <= mem[rdPtr];
        rdPtr  <= rdPtr + 1'b1;
      end
    end
  end

endmodule

// File: rtl/fault_capture_buf.sv
module fault_capture_buf
  import fcap_pkg::*;
#(
  parameter int NCH   = 2,
  parameter int CH_W  = 16,
  parameter int TS_W  = 16,
  parameter int DEPTH = 16,
  localparam int ADDR_W  = $clog2(DEPTH),
  localparam int CNT_W   = ADDR_W + 1,
  localparam int FRAME_W = NCH * CH_W,
  localparam int ENT_W   = TS_W + FRAME_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               frameValid,
  input  logic [FRAME_W-1:0] frameData,
  input  logic               trigIn,
  input  logic [CNT_W-1:0]   preLen,
  input  logic [CNT_W-1:0]   postLen,
  input  logic               armIn,
  input  logic               rdEn,
  output logic [ENT_W-1:0]   rdData,
  output logic               rdValid,
  output logic               busy,
  output logic               done,
  output logic               shortPre
);

  capStrobe_t       strb;
  logic [CNT_W-1:0] keptPre;

  fcap_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .frameValid(frameValid), .trigIn(trigIn),
    .armIn(armIn), .rdEn(rdEn), .preLen(preLen), .postLen(postLen),
    .strb(strb), .keptPre(keptPre), .busy(busy), .done(done),
    .shortPre(shortPre)
  );

  fcap_path #(.FRAME_W(FRAME_W), .TS_W(TS_W), .DEPTH(DEPTH)) u_path (
    .clk(clk), .rstN(rstN), .strb(strb), .frameData(frameData),
    .keptPre(keptPre), .rdData(rdData), .rdValid(rdValid)
  );

endmodule

// File: rtl/fcap_checker.sv
module fcap_checker (
  input logic clk,
  input logic rstN,
  input logic armIn,
  input logic trigIn,
  input logic rdEn,
  input logic busy,
  input logic done,
  input logic shortPre,
  input logic rdValid
);

  // R5: the two phase flags never overlap
  a_r5_busy_done_excl: assert property (@(posedge clk) disable iff (!rstN)
    !(busy && done));

  // R5: completion only follows an active capture
  a_r5_done_from_busy: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> $past(busy));

  // R2: a capture starts only on an arm request
  a_r2_busy_needs_arm: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(armIn));

  // R4: the short-history flag is raised only by a trigger
  a_r4_short_on_trig: assert property (@(posedge clk) disable iff (!rstN)
    $rose(shortPre) |-> $past(trigIn) && $past(busy));

  // R9: host data appears only after a read in the done state
  a_r9_read_lockout: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> $past(rdEn) && $past(done));

endmodule

bind fault_capture_buf fcap_checker u_fcapChk (
  .clk(clk), .rstN(rstN), .armIn(armIn), .trigIn(trigIn), .rdEn(rdEn),
  .busy(busy), .done(done), .shortPre(shortPre), .rdValid(rdValid)
);

// File: tb/tb_fault_capture_buf.sv
module tb_fault_capture_buf;

  localparam int DEPTH = 8;
  localparam int NCH   = 2;
  localparam int CH_W  = 16;
  localparam int TS_W  = 16;
  localparam int CNT_W = $clog2(DEPTH) + 1;
  localparam int FW    = NCH * CH_W;
  localparam int EW    = TS_W + FW;

  typedef struct packed {
    int pre;
    int post;
    int nPre;
    bit gap;
  } row_t;

  localparam int NROW = 7;
  localparam row_t ROWS [NROW] = '{
    '{3, 4, 10, 1'b0},
    '{5, 3, 2,  1'b0},
    '{0, 5, 4,  1'b1},
    '{4, 0, 6,  1'b1},
    '{4, 4, 20, 1'b1},
    '{8, 0, 9,  1'b0},
    '{2, 6, 8,  1'b0}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic frameValid = 1'b0;
  logic [FW-1:0] frameData = '0;
  logic trigIn = 1'b0;
  logic [CNT_W-1:0] preLen = '0;
  logic [CNT_W-1:0] postLen = '0;
  logic armIn = 1'b0;
  logic rdEn = 1'b0;
  logic [EW-1:0] rdData;
  logic rdValid, busy, done, shortPre;

  always #10 clk = ~clk;  // 50 MHz

  fault_capture_buf #(.NCH(NCH), .CH_W(CH_W), .TS_W(TS_W), .DEPTH(DEPTH)) dut (
    .clk(clk), .rstN(rstN), .frameValid(frameValid), .frameData(frameData),
    .trigIn(trigIn), .preLen(preLen), .postLen(postLen), .armIn(armIn),
    .rdEn(rdEn), .rdData(rdData), .rdValid(rdValid), .busy(busy),
    .done(done), .shortPre(shortPre)
  );

  // timestamp per R8: 0 after reset, +1 every clock
  logic [TS_W-1:0] tsModel;
  always @(posedge clk or negedge rstN)
    if (!rstN) tsModel <= '0; else tsModel <= tsModel + 1'b1;

  int total = 0;
  int fails = 0;
  bit finished = 1'b0;
  logic [15:0] seqNo = 16'h0100;

  logic [FW-1:0]   preD  [32];
  logic [TS_W-1:0] preT  [32];
  logic [FW-1:0]   postD [32];
  logic [TS_W-1:0] postT [32];

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drives one frame for one edge; returns data and the timestamp it gets
  task automatic sendFrame(input bit gap, output logic [FW-1:0] d,
                           output logic [TS_W-1:0] t);
    @(negedge clk);
    d = {seqNo, ~seqNo};
    seqNo = seqNo + 1'b1;
    frameValid = 1'b1;
    frameData  = d;
    t = tsModel;
    @(negedge clk);
    frameValid = 1'b0;
    if (gap) @(negedge clk);
  endtask

  task automatic readOne(output logic [EW-1:0] v, output logic vld);
    @(negedge clk);
    rdEn = 1'b1;
    @(negedge clk);
    rdEn = 1'b0;
    v = rdData;
    vld = rdValid;
  endtask

  initial begin
    logic [FW-1:0] d;
    logic [TS_W-1:0] t;
    logic [EW-1:0] v;
    logic vld;

    repeat (3) @(negedge clk);
    // R1: reset state
    check(!busy && !done && !shortPre && !rdValid, "R1 reset flags",
          {busy, done, shortPre, rdValid}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!busy && !done, "R1 idle after reset", {busy, done}, 0);

    // R6: trigger while idle is ignored
    trigIn = 1'b1;
    @(negedge clk);
    trigIn = 1'b0;
    @(negedge clk);
    check(!busy && !done, "R6 idle trigger ignored", {busy, done}, 0);

    // R9: read while idle gives nothing
    readOne(v, vld);
    check(!vld, "R9 idle read refused", vld, 0);

    for (int r = 0; r < NROW; r++) begin
      int kept;
      int nRead;
      preLen  = CNT_W'(ROWS[r].pre);
      postLen = CNT_W'(ROWS[r].post);
      kept  = (ROWS[r].nPre < ROWS[r].pre) ? ROWS[r].nPre : ROWS[r].pre;
      nRead = kept + ROWS[r].post;

      // R2: arm
      @(negedge clk);
      armIn = 1'b1;
      @(negedge clk);
      armIn = 1'b0;
      check(busy && !done && !shortPre, "R2 arm starts capture",
            {busy, done, shortPre}, 3'b100);

      for (int i = 0; i < ROWS[r].nPre; i++) begin
        sendFrame(ROWS[r].gap, d, t);
        preD[i] = d;
        preT[i] = t;
      end

      // R9: read while busy refused
      readOne(v, vld);
      check(!vld, "R9 busy read refused", vld, 0);

      // trigger with a frame in the same cycle (R3: discarded)
      @(negedge clk);
      trigIn = 1'b1;
      frameValid = 1'b1;
      frameData = '1;
      @(negedge clk);
      trigIn = 1'b0;
      frameValid = 1'b0;
      // R2 arm ignored while busy, R6 second trigger ignored
      armIn = 1'b1;
      trigIn = 1'b1;
      @(negedge clk);
      armIn = 1'b0;
      trigIn = 1'b0;
      if (ROWS[r].post > 0)
        check(busy, "R2 arm during capture ignored", busy, 1);

      for (int i = 0; i < ROWS[r].post + 2; i++) begin
        sendFrame(ROWS[r].gap, d, t);
        if (i < ROWS[r].post) begin
          postD[i] = d;
          postT[i] = t;
        end
      end

      for (int w = 0; w < 20 && !done; w++) @(negedge clk);
      check(done && !busy, "R5 done after tail", {busy, done}, 2'b01);
      check(shortPre == (ROWS[r].nPre < ROWS[r].pre), "R4 short history flag",
            shortPre, (ROWS[r].nPre < ROWS[r].pre));

      // R6: trigger in done state ignored, later frames not stored (R5)
      @(negedge clk);
      trigIn = 1'b1;
      @(negedge clk);
      trigIn = 1'b0;
      sendFrame(1'b0, d, t);
      sendFrame(1'b0, d, t);
      check(done && !busy, "R6 done trigger ignored", {busy, done}, 2'b01);

      for (int k = 0; k < nRead; k++) begin
        logic [FW-1:0] eD;
        logic [TS_W-1:0] eT;
        if (k < kept) begin
          eD = preD[ROWS[r].nPre - kept + k];
          eT = preT[ROWS[r].nPre - kept + k];
        end else begin
          eD = postD[k - kept];
          eT = postT[k - kept];
        end
        readOne(v, vld);
        check(vld, "R7 read valid", vld, 1);
        check(v[FW-1:0] == eD, "R7 frame order", v[FW-1:0], eD);
        check(v[EW-1:FW] == eT, "R8 timestamp", v[EW-1:FW], eT);
      end
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

endmodule